// File: doc/BRIEF.md
# Pairing and NVM Lock Unit

This block sits behind a 16-bit register port and guards a small bank of non-volatile shadow words. The non-volatile contents are modelled as registers that are loaded from parameters at reset. The physical programming sequence of the memory is outside the block. The host reaches every function through single-cycle write and read strobes on a 7-bit word address.

Writing a magic 16-bit password turns on a test mode. While test mode is on, the host can read the 64-bit die-unique pairing code, which is spread over four word addresses. Test mode also opens a debug word for both reading and writing. A host that writes the four code words back, in any order, is checked against the stored code, and a full match marks the device as paired. These writes only feed the comparison; the stored code never changes.

One lock word holds two bytes. A program-lock byte of 0xFF refuses all further programming of the shadow words, and a read-lock byte of 0xFF hides the shadow words from reads outside test mode. Both locks are one-way. They are cleared only by reset. The paired, program-lock and read-lock flags are exported as pins and also appear in a status word.

Top module: `nvm_guard`

## Requirements
- R1: After reset, test_mode_o, paired_o, prog_lock_o and read_lock_o are 0 when the preloaded lock word is 0x0000, and rdata_o is 0x0000.
- R2: A write of 0x7A53 to address 0x0A sets test_mode_o after that clock edge. A write of any other value to 0x0A clears it.
- R3: The 64-bit pairing code is read at addresses 0x19 (bits 15:0), 0x1A (bits 31:16), 0x1B (bits 47:32) and 0x1C (bits 63:48), but only while test mode is on. Outside test mode these reads return 0x0000.
- R4: Host writes to 0x19 to 0x1C never change the pairing code that is read back.
- R5: A comparison is made on the write that completes the set of all four code words written since the last comparison, in any order; a rewritten word replaces its earlier value. After that write, paired_o is 1 if all four words matched and 0 otherwise. The flag also reads as bit 11 of the status word at 0x02.
- R6: Address 0x1D holds the lock word. A write to 0x1D whose bits 15:8 are 0xFF sets prog_lock_o, also status bit 10. After that, writes to 0x1D and 0x11 are ignored, and reads are still served.
- R7: A write to 0x1D whose bits 7:0 are 0xFF sets read_lock_o, also status bit 9. After that, reads of 0x10 and 0x1D return 0x0000 outside test mode and return their contents in test mode.
- R8: Address 0x11 is a debug word. It is read and written only in test mode. Outside test mode it reads 0x0000 and writes to it are ignored.
- R9: Address 0x10 reads the revision word: major revision in bits 15:12, minor in bits 11:8, test revision in bits 7:0. Writes to it are ignored.
- R10: Once set, prog_lock_o and read_lock_o stay set until reset, even when the lock byte is later rewritten with another value.
- R11: rdata_o holds the addressed word one cycle after a read strobe. It is 0x0000 after any cycle without a read strobe and for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; reloads the shadow words |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 7 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| test_mode_o | output | 1 | Test mode active |
| paired_o | output | 1 | Pairing code matched on the last comparison |
| prog_lock_o | output | 1 | Programming of shadow words refused |
| read_lock_o | output | 1 | Shadow words hidden outside test mode |

## Verification
Every flag the block exports (test mode, paired, both locks) changes on the clock edge that accepts the write, so it is due one cycle after the strobe. Read data is registered and is due on the edge that takes the read strobe. The bench drives each strobe on a falling edge and samples at the next falling edge, which falls between the edge that makes the result and the edge that could change it. Because of this, every check for a write or a read sits exactly one edge after its stimulus.

// File: rtl/nvm_guard_pkg.sv
`timescale 1ns/1ps
package nvm_guard_pkg;
  localparam int DW         = 16;
  localparam int AW         = 7;
  localparam int BYTE_W     = 8;
  localparam int CODE_WORDS = 4;
  localparam int CW         = DW * CODE_WORDS;
  localparam int IW         = $clog2(CODE_WORDS);

  localparam logic [AW-1:0] A_STATUS = 7'h02;
  localparam logic [AW-1:0] A_PASS   = 7'h0A;
  localparam logic [AW-1:0] A_REV    = 7'h10;
  localparam logic [AW-1:0] A_DBG    = 7'h11;
  localparam logic [AW-1:0] A_CODE   = 7'h19;
  localparam logic [AW-1:0] A_LOCK   = 7'h1D;

  localparam logic [DW-1:0]     PASS_KEY = 16'h7A53;
  localparam logic [BYTE_W-1:0] LOCK_KEY = 8'hFF;

  localparam int PAIR_BIT  = 11;
  localparam int PLOCK_BIT = 10;
  localparam int RLOCK_BIT = 9;
endpackage

// File: rtl/nvm_guard_lock.sv
`timescale 1ns/1ps
module nvm_guard_lock
  import nvm_guard_pkg::*;
#(
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] word_o,
  output logic          prog_lock_o,
  output logic          read_lock_o
);
  localparam logic [BYTE_W-1:0] INIT_PROG = INIT[DW-1 -: BYTE_W];
  localparam logic [BYTE_W-1:0] INIT_READ = INIT[BYTE_W-1:0];

  // lock flags are sticky: only reset clears them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o      <= INIT;
      prog_lock_o <= (INIT_PROG == LOCK_KEY);
      read_lock_o <= (INIT_READ == LOCK_KEY);
    end else if (wr_i && !prog_lock_o) begin
      word_o <= wdata_i;
      if (wdata_i[DW-1 -: BYTE_W] == LOCK_KEY) prog_lock_o <= 1'b1;
      if (wdata_i[BYTE_W-1:0] == LOCK_KEY)     read_lock_o <= 1'b1;
    end
  end

  p_prog_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_lock_o |=> prog_lock_o);
  p_read_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_lock_o |=> read_lock_o);
  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_lock_o |=> $stable(word_o));
  p_lock_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !prog_lock_o && wdata_i[DW-1 -: BYTE_W] == LOCK_KEY) |=> prog_lock_o);
endmodule

// File: rtl/nvm_guard_pair.sv
`timescale 1ns/1ps
module nvm_guard_pair
  import nvm_guard_pkg::*;
#(
  parameter logic [CW-1:0] CODE = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CODE_WORDS-1:0] sel_i,
  input  logic [DW-1:0]         wdata_i,
  output logic                  paired_o
);
  logic [CODE_WORDS-1:0] seen_q, hit_q, hit_now, seen_nx, hit_nx;
  logic                  take;

  for (genvar g = 0; g < CODE_WORDS; g++) begin : g_cmp
    assign hit_now[g] = (wdata_i == CODE[g*DW +: DW]);
  end

  assign take    = wr_en_i && (|sel_i);
  assign seen_nx = seen_q | sel_i;
  assign hit_nx  = (hit_q & ~sel_i) | (hit_now & sel_i);

  // only per-word match bits are kept; written words are never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= '0;
      hit_q    <= '0;
      paired_o <= 1'b0;
    end else if (take) begin
      if (&seen_nx) begin
        paired_o <= &hit_nx;
        seen_q   <= '0;
        hit_q    <= '0;
      end else begin
        seen_q <= seen_nx;
        hit_q  <= hit_nx;
      end
    end
  end

  p_sel_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
  p_pair_update_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(paired_o));
endmodule

// File: rtl/nvm_guard_access.sv
`timescale 1ns/1ps
module nvm_guard_access
  import nvm_guard_pkg::*;
#(
  parameter logic [CW-1:0] CODE     = '0,
  parameter logic [DW-1:0] REV      = '0,
  parameter logic [DW-1:0] DBG_INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] lock_word_i,
  input  logic          paired_i,
  input  logic          prog_lock_i,
  input  logic          read_lock_i,
  output logic [DW-1:0] rdata_o,
  output logic          test_mode_o
);
  localparam logic [AW-1:0] A_CODE_END = AW'(int'(A_CODE) + CODE_WORDS);

  logic [DW-1:0] dbg_q, rd_val;
  logic          code_hit, hide;
  logic [IW-1:0] code_idx;

  assign code_hit = (addr_i >= A_CODE) && (addr_i < A_CODE_END);
  assign code_idx = IW'(addr_i - A_CODE);
  assign hide     = read_lock_i && !test_mode_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_mode_o <= 1'b0;
      dbg_q       <= DBG_INIT;
    end else begin
      if (wr_en_i && addr_i == A_PASS) test_mode_o <= (wdata_i == PASS_KEY);
      if (wr_en_i && addr_i == A_DBG && test_mode_o && !prog_lock_i) dbg_q <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    if (code_hit) begin
      if (test_mode_o) rd_val = CODE[code_idx*DW +: DW];
    end else begin
      case (addr_i)
        A_STATUS: begin
          rd_val[PAIR_BIT]  = paired_i;
          rd_val[PLOCK_BIT] = prog_lock_i;
          rd_val[RLOCK_BIT] = read_lock_i;
        end
        A_REV:   if (!hide) rd_val = REV;
        A_DBG:   if (test_mode_o) rd_val = dbg_q;
        A_LOCK:  if (!hide) rd_val = lock_word_i;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? rd_val : '0;
  end

  p_test_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_PASS) |=> (test_mode_o == ($past(wdata_i) == PASS_KEY)));
  p_code_hidden_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && code_hit && !test_mode_o) |=> (rdata_o == '0));
  p_read_hide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && read_lock_i && !test_mode_o && (addr_i == A_REV || addr_i == A_LOCK))
      |=> (rdata_o == '0));
  p_dbg_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DBG && !test_mode_o) |=> $stable(dbg_q));
  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
endmodule

// File: rtl/nvm_guard.sv
`timescale 1ns/1ps
module nvm_guard
  import nvm_guard_pkg::*;
#(
  parameter logic [CW-1:0] PAIR_CODE = 64'h1234_5678_9ABC_DEF0,
  parameter logic [DW-1:0] REV_WORD  = 16'h2107,
  parameter logic [DW-1:0] LOCK_INIT = 16'h0000,
  parameter logic [DW-1:0] DBG_INIT  = 16'h0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          test_mode_o,
  output logic          paired_o,
  output logic          prog_lock_o,
  output logic          read_lock_o
);
  logic [CODE_WORDS-1:0] code_sel;
  logic [DW-1:0]         lock_word;
  logic                  lock_wr;

  for (genvar g = 0; g < CODE_WORDS; g++) begin : g_sel
    assign code_sel[g] = (addr_i == AW'(int'(A_CODE) + g));
  end

  assign lock_wr = wr_en_i && (addr_i == A_LOCK);

  nvm_guard_lock #(.INIT(LOCK_INIT)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (lock_wr),
    .wdata_i     (wdata_i),
    .word_o      (lock_word),
    .prog_lock_o (prog_lock_o),
    .read_lock_o (read_lock_o)
  );

  nvm_guard_pair #(.CODE(PAIR_CODE)) u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sel_i    (code_sel),
    .wdata_i  (wdata_i),
    .paired_o (paired_o)
  );

  nvm_guard_access #(
    .CODE     (PAIR_CODE),
    .REV      (REV_WORD),
    .DBG_INIT (DBG_INIT)
  ) u_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .lock_word_i (lock_word),
    .paired_i    (paired_o),
    .prog_lock_i (prog_lock_o),
    .read_lock_i (read_lock_o),
    .rdata_o     (rdata_o),
    .test_mode_o (test_mode_o)
  );
endmodule

// File: tb/nvm_guard_bench.sv
`timescale 1ns/1ps
module nvm_guard_bench;
  localparam logic [63:0] CODE = 64'h1234_5678_9ABC_DEF0;
  localparam logic [15:0] REV  = 16'h2107;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tm, paired, plock, rlock;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic        m_tm, m_paired, m_plock, m_rlock;
  logic [15:0] m_dbg, m_lockw;
  logic [3:0]  m_seen, m_hit;

  always #2.5 clk = ~clk;

  nvm_guard #(.PAIR_CODE(CODE), .REV_WORD(REV)) u_nvm_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .test_mode_o(tm), .paired_o(paired), .prog_lock_o(plock), .read_lock_o(rlock)
  );

  function automatic logic [15:0] code_word(int i);
    return CODE[i*16 +: 16];
  endfunction

  function automatic logic [15:0] exp_read(logic [6:0] a);
    if (a >= 7'h19 && a <= 7'h1C) return m_tm ? code_word(int'(a) - 'h19) : 16'h0;
    case (a)
      7'h02:   return {4'h0, m_paired, m_plock, m_rlock, 9'h0};
      7'h10:   return (m_rlock && !m_tm) ? 16'h0 : REV;
      7'h11:   return m_tm ? m_dbg : 16'h0;
      7'h1D:   return (m_rlock && !m_tm) ? 16'h0 : m_lockw;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_write(logic [6:0] a, logic [15:0] d);
    if (a == 7'h0A) m_tm = (d == 16'h7A53);
    else if (a == 7'h11) begin
      if (m_tm && !m_plock) m_dbg = d;
    end else if (a == 7'h1D) begin
      if (!m_plock) begin
        m_lockw = d;
        if (d[15:8] == 8'hFF) m_plock = 1'b1;
        if (d[7:0] == 8'hFF)  m_rlock = 1'b1;
      end
    end else if (a >= 7'h19 && a <= 7'h1C) begin
      int i;
      i = int'(a) - 'h19;
      m_seen[i] = 1'b1;
      m_hit[i]  = (d == code_word(i));
      if (&m_seen) begin
        m_paired = &m_hit;
        m_seen = '0;
        m_hit = '0;
      end
    end
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    check(req, {12'h0, tm, paired, plock, rlock}, {12'h0, m_tm, m_paired, m_plock, m_rlock});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    m_tm = 0; m_paired = 0; m_plock = 0; m_rlock = 0;
    m_dbg = '0; m_lockw = '0; m_seen = '0; m_hit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_chk(string req, logic [6:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // reset state
    check("R1 flags", {12'h0, tm, paired, plock, rlock}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    rd_chk("R3 hidden code", 7'h19, 16'h0);
    rd_chk("R3 hidden code", 7'h1C, 16'h0);
    rd_chk("R9 revision", 7'h10, REV);
    rd_chk("R11 unmapped", 7'h30, 16'h0);
    @(negedge clk);
    check("R11 idle zero", rdata, 16'h0);

    // password
    wr(7'h0A, 16'h1234);
    check("R2 wrong password", {15'h0, tm}, 16'h0);
    wr(7'h0A, 16'h7A53);
    check("R2 password", {15'h0, tm}, 16'h1);
    for (int i = 0; i < 4; i++) rd_chk("R3 code word", 7'(7'h19 + i), code_word(i));

    // pairing, out of order
    wr(7'h1C, code_word(3));
    wr(7'h19, code_word(0));
    wr(7'h1B, code_word(2));
    check("R5 not yet paired", {15'h0, paired}, 16'h0);
    wr(7'h1A, code_word(1));
    check("R5 paired", {15'h0, paired}, 16'h1);
    rd_chk("R5 status bit 11", 7'h02, 16'h0800);
    // mismatch clears
    wr(7'h19, 16'h0BAD);
    wr(7'h1A, code_word(1));
    wr(7'h1B, code_word(2));
    wr(7'h1C, code_word(3));
    check("R5 mismatch clears", {15'h0, paired}, 16'h0);
    rd_chk("R4 code kept", 7'h19, code_word(0));
    // rewrite replaces the earlier word
    wr(7'h19, 16'h0BAD);
    wr(7'h19, code_word(0));
    wr(7'h1A, code_word(1));
    wr(7'h1B, code_word(2));
    wr(7'h1C, code_word(3));
    check("R5 rewrite pairs", {15'h0, paired}, 16'h1);

    // debug word
    wr(7'h11, 16'hBEEF);
    rd_chk("R8 debug rw", 7'h11, 16'hBEEF);
    wr(7'h0A, 16'h0000);
    rd_chk("R8 debug hidden", 7'h11, 16'h0);
    wr(7'h11, 16'h1111);
    wr(7'h0A, 16'h7A53);
    rd_chk("R8 debug write ignored", 7'h11, 16'hBEEF);

    // revision is read-only
    wr(7'h10, 16'hFFFF);
    rd_chk("R9 revision read-only", 7'h10, REV);

    // read lock
    wr(7'h0A, 16'h0000);
    wr(7'h1D, 16'h00FF);
    check("R7 read lock set", {15'h0, rlock}, 16'h1);
    rd_chk("R7 revision hidden", 7'h10, 16'h0);
    rd_chk("R7 lock word hidden", 7'h1D, 16'h0);
    rd_chk("R7 status", 7'h02, 16'h0A00);
    wr(7'h0A, 16'h7A53);
    rd_chk("R7 revision in test mode", 7'h10, REV);
    wr(7'h1D, 16'h0000);
    check("R10 read lock sticky", {15'h0, rlock}, 16'h1);
    rd_chk("R10 lock word rewritten", 7'h1D, 16'h0000);

    // program lock
    wr(7'h1D, 16'hFF00);
    check("R6 prog lock set", {15'h0, plock}, 16'h1);
    wr(7'h1D, 16'h1234);
    rd_chk("R6 lock write refused", 7'h1D, 16'hFF00);
    wr(7'h11, 16'h2222);
    rd_chk("R6 debug write refused", 7'h11, 16'hBEEF);
    check("R10 prog lock sticky", {15'h0, plock}, 16'h1);
    rd_chk("R6 status", 7'h02, 16'h0E00);

    // reset clears locks
    do_reset();
    check("R1 locks cleared", {12'h0, tm, paired, plock, rlock}, 16'h0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [6:0]  a;
      logic [15:0] d;
      int k;
      k = int'($urandom % 9);
      case (k)
        0: a = 7'h02; 1: a = 7'h0A; 2: a = 7'h10; 3: a = 7'h11;
        4: a = 7'h19; 5: a = 7'h1A; 6: a = 7'h1B; 7: a = 7'h1C;
        default: a = 7'h1D;
      endcase
      d = 16'($urandom);
      if (a == 7'h0A && ($urandom % 2) == 0) d = 16'h7A53;
      if (a >= 7'h19 && a <= 7'h1C && ($urandom % 4) != 0) d = code_word(int'(a) - 'h19);
      if (a == 7'h1D && ($urandom % 64) == 0) d[7:0] = 8'hFF;
      if (a == 7'h1D && ($urandom % 200) == 0) d[15:8] = 8'hFF;
      if (($urandom % 2) == 0) begin
        wr(a, d);
        check_flags("R5 R6 R7 R2 random flags");
      end else begin
        rd_chk("R3 R7 R8 R11 random read", a, exp_read(a));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule